// File: doc/BRIEF.md
# Register-Mapped System Timer

This peripheral gives software three time bases behind one 32-bit register bus. A free-running stamp counter advances by one on every clock. Software may overwrite it, usually with zero to restart it, and reads it to measure elapsed time. Two interval timers count down from a programmed reload value. Each one either reloads itself and keeps going (periodic) or stops after its first expiry (single-shot). Every expiry sets a sticky pending flag. The two interval flags also drive level interrupt lines.

Each interval timer is a four-state machine. ST_HALT is stopped, ST_CYCLE is counting periodically, ST_SINGLE is counting in single-shot mode, and ST_SPENT means a single-shot run has ended. The transitions are:
- A control write with the enable bit clear goes from any state to ST_HALT.
- A control write with enable set and the single-shot bit clear goes to ST_CYCLE.
- A control write with enable set and the single-shot bit set goes to ST_SINGLE.
- An expiry in ST_SINGLE goes to ST_SPENT.
- Without a control write, every other state holds.

A control write that enables a timer from ST_HALT or ST_SPENT also loads the count with the reload value. A control write to a timer that is already running only updates the stored reload value and the mode bits.

The bus is a single-cycle interface: address, write strobe, write data and combinational read data. The word map is:

| Offset | Register |
|--------|----------|
| 0x00 | stamp counter |
| 0x04 | timer 0 count |
| 0x08 | timer 0 control |
| 0x0C | timer 1 count |
| 0x10 | timer 1 control |
| 0x20 | pending flags |

Top module: `os_timer_top`

## Requirements
- R1: After reset, both count registers, both control registers, the pending flags and both interrupt lines are zero.
- R2: The stamp counter (offset 0x00) rises by one every clock, wraps at 32 bits and takes the written value on a bus write, so writing 0 restarts it from zero.
- R3: When the stamp counter steps from all ones to zero, pending bit 2 is set.
- R4: In a control register (timer 0 at 0x08, timer 1 at 0x10), bit 0 is enable and bit 1 selects single-shot. The reload value is bits [31:2] with the two low bits forced to zero. The register reads back the word last written.
- R5: A control write with bit 0 set to a stopped or spent timer loads its count with the reload value. The count then drops by one per clock.
- R6: A running timer whose count is zero at a clock edge expires on that edge. Timer 0 sets pending bit 0 and timer 1 sets pending bit 1. In periodic mode the count is reloaded, so the period is reload+1 cycles.
- R7: In single-shot mode a timer expires once, then holds its count at zero and raises no further flags.
- R8: A control write that keeps enable set on a running timer leaves the current count alone. The new reload value is used at the next reload.
- R9: Writing 0 to a control register stops the timer. Its count freezes and it sets no flags.
- R10: Writing 1 to a bit of the pending register (offset 0x20) clears that bit. Writing 0 leaves it unchanged.
- R11: Interrupt line k is high exactly while pending bit k is set, and stays high until software clears that bit.
- R12: Count registers (0x04, 0x0C) read the live count and accept writes. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the accessed register |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| tmr_irq | output | 2 | Level interrupt per interval timer |

## Verification
The in-line properties assume the following about the bus:
- At most one register is written per cycle.
- The write strobe is never unknown once reset is released.
- A count write and a control write to the same timer never coincide.

The bench honours these assumptions by driving every bus access from a single task that changes the pins only at the falling edge and holds the strobe for exactly one rising edge. It reads the combinational data a moment after setting the address, with no write pending.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;

    // interval timer states
    typedef enum logic [1:0] {
        ST_HALT   = 2'd0,
        ST_CYCLE  = 2'd1,
        ST_SINGLE = 2'd2,
        ST_SPENT  = 2'd3
    } tmr_state_e;

    // control word layout
    localparam int unsigned EN_BIT    = 0;
    localparam int unsigned ONE_BIT   = 1;
    localparam int unsigned CTRL_LO_W = 2;

    // register map (byte offsets)
    localparam int unsigned N_TMR          = 2;
    localparam int unsigned N_FLAG         = N_TMR + 1;
    localparam int unsigned OFS_STAMP      = 32'h00;
    localparam int unsigned OFS_TMR_BASE   = 32'h04;
    localparam int unsigned OFS_TMR_STRIDE = 32'h08;
    localparam int unsigned OFS_STATUS     = 32'h20;

endpackage

// File: rtl/ostmr_stamp.sv
module ostmr_stamp #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ts_o,
    output logic          wrap_o
);

    logic [DW-1:0] ts_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  ts_q <= '0;
        else if (we) ts_q <= wdata;
        else         ts_q <= ts_q + 1'b1;
    end

    always_comb begin
        ts_o   = ts_q;
        wrap_o = !we && (&ts_q);
    end

    AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ts_q == $past(ts_q) + 1'b1); // R2
    AST_TS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ts_q == $past(wdata)); // R2
    AST_TS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> ts_q == '0); // R3

endmodule

// File: rtl/ostmr_interval.sv
module ostmr_interval
    import ostmr_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic          cnt_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cnt_o,
    output logic [DW-1:0] ctrl_o,
    output logic          expire_o
);

    localparam int unsigned LO_W = CTRL_LO_W;

    tmr_state_e    state_q, state_d;
    logic [DW-1:0] ctrl_q, cnt_q;
    logic [DW-1:0] reload_w, new_reload_w;
    logic          running, at_zero, load_start, stop_req, expire;

    assign reload_w     = {ctrl_q[DW-1:LO_W], {LO_W{1'b0}}};
    assign new_reload_w = {wdata[DW-1:LO_W], {LO_W{1'b0}}};
    assign running      = (state_q == ST_CYCLE) || (state_q == ST_SINGLE);
    assign at_zero      = (cnt_q == '0);
    assign load_start   = ctrl_we && wdata[EN_BIT] && !running;
    assign stop_req     = ctrl_we && !wdata[EN_BIT];
    assign expire       = running && at_zero && !cnt_we;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (ctrl_we) begin
            if (!wdata[EN_BIT])      state_d = ST_HALT;
            else if (wdata[ONE_BIT]) state_d = ST_SINGLE;
            else                     state_d = ST_CYCLE;
        end else begin
            unique case (state_q)
                ST_HALT:   state_d = ST_HALT;
                ST_CYCLE:  state_d = ST_CYCLE;
                ST_SINGLE: if (expire) state_d = ST_SPENT;
                ST_SPENT:  state_d = ST_SPENT;
                default:   state_d = ST_HALT;
            endcase
        end
    end

    // control word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= wdata;
    end

    // down counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_we) begin
            cnt_q <= wdata;
        end else if (load_start) begin
            cnt_q <= new_reload_w;
        end else if (running && !stop_req) begin
            if (!at_zero)                  cnt_q <= cnt_q - 1'b1;
            else if (state_q == ST_CYCLE)  cnt_q <= reload_w;
        end
    end

    // outputs
    always_comb begin
        cnt_o    = cnt_q;
        ctrl_o   = ctrl_q;
        expire_o = expire;
    end

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && wdata[EN_BIT] && !running && !cnt_we)
        |=> cnt_q[DW-1:LO_W] == $past(wdata[DW-1:LO_W]) && cnt_q[LO_W-1:0] == '0); // R4
    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !at_zero && !cnt_we && !ctrl_we) |=> cnt_q == $past(cnt_q) - 1'b1); // R5
    AST_PERIOD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CYCLE && at_zero && !cnt_we && !ctrl_we)
        |=> cnt_q[DW-1:LO_W] == $past(ctrl_q[DW-1:LO_W]) && cnt_q[LO_W-1:0] == '0); // R6
    AST_SPENT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPENT && !ctrl_we && !cnt_we) |=> $stable(cnt_q) && !expire_o); // R7
    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !ctrl_we && !cnt_we) |=> $stable(cnt_q)); // R9
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |-> !expire_o); // R9

endmodule

// File: rtl/ostmr_status.sv
module ostmr_status #(
    parameter int unsigned NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic          clr_we,
    input  logic [NF-1:0] clr_mask,
    output logic [NF-1:0] pend_o
);

    logic [NF-1:0] pend_q;

    for (genvar i = 0; i < NF; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       pend_q[i] <= 1'b0;
            else if (set_i[i])                pend_q[i] <= 1'b1;
            else if (clr_we && clr_mask[i])   pend_q[i] <= 1'b0;
        end

        AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> pend_q[i]); // R6
        AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[i] && !(clr_we && clr_mask[i])) |=> pend_q[i]); // R10
        AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_mask[i] && !set_i[i]) |=> !pend_q[i]); // R10
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/os_timer_top.sv
module os_timer_top
    import ostmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [N_TMR-1:0]  tmr_irq
);

    localparam logic [ADDR_W-1:0] A_STAMP  = ADDR_W'(OFS_STAMP);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

    logic [DW-1:0]     ts_w;
    logic              wrap_w;
    logic [DW-1:0]     cnt_a  [N_TMR];
    logic [DW-1:0]     ctrl_a [N_TMR];
    logic [N_TMR-1:0]  exp_w;
    logic [N_FLAG-1:0] set_w, pend_w;
    logic              stamp_we, status_we;

    assign stamp_we  = bus_we && (bus_addr == A_STAMP);
    assign status_we = bus_we && (bus_addr == A_STATUS);

    ostmr_stamp #(.DW(DW)) u_stamp (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (stamp_we),
        .wdata  (bus_wdata),
        .ts_o   (ts_w),
        .wrap_o (wrap_w)
    );

    for (genvar k = 0; k < N_TMR; k++) begin : g_tmr
        localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_TMR_BASE + OFS_TMR_STRIDE * k);
        localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_TMR_BASE + OFS_TMR_STRIDE * k + 4);

        logic cnt_we, ctrl_we;
        assign cnt_we  = bus_we && (bus_addr == A_CNT);
        assign ctrl_we = bus_we && (bus_addr == A_CTRL);

        ostmr_interval #(.DW(DW)) u_ivl (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctrl_we  (ctrl_we),
            .cnt_we   (cnt_we),
            .wdata    (bus_wdata),
            .cnt_o    (cnt_a[k]),
            .ctrl_o   (ctrl_a[k]),
            .expire_o (exp_w[k])
        );

        assign set_w[k] = exp_w[k];

        AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_irq[k] && !(status_we && bus_wdata[k])) |=> tmr_irq[k]); // R11
        AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
            exp_w[k] |=> tmr_irq[k]); // R11
    end

    assign set_w[N_TMR] = wrap_w;

    ostmr_status #(.NF(N_FLAG)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_w),
        .clr_we   (status_we),
        .clr_mask (bus_wdata[N_FLAG-1:0]),
        .pend_o   (pend_w)
    );

    assign tmr_irq = pend_w[N_TMR-1:0];

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_STAMP)  bus_rdata = ts_w;
        if (bus_addr == A_STATUS) bus_rdata = DW'(pend_w);
        for (int k = 0; k < N_TMR; k++) begin
            if (bus_addr == ADDR_W'(OFS_TMR_BASE + OFS_TMR_STRIDE * k))
                bus_rdata = cnt_a[k];
            if (bus_addr == ADDR_W'(OFS_TMR_BASE + OFS_TMR_STRIDE * k + 4))
                bus_rdata = ctrl_a[k];
        end
    end

endmodule

// File: tb/sim_os_timer_top.sv
`timescale 1ns/1ps
module sim_os_timer_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  tmr_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [7:0] A_TS = 8'h00, A_C0 = 8'h04, A_K0 = 8'h08,
                           A_C1 = 8'h0C, A_K1 = 8'h10, A_ST = 8'h20;

    always #5 clk = ~clk;

    os_timer_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_irq(tmr_irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_C0, v); chk("R1 cnt0", v, 0);
        rd(A_K0, v); chk("R1 ctrl0", v, 0);
        rd(A_C1, v); chk("R1 cnt1", v, 0);
        step(1);
        rd(A_K1, v); chk("R1 ctrl1", v, 0);
        rd(A_ST, v); chk("R1 status", v, 0);
        chk("R1 irq", {30'd0, tmr_irq}, 0);
    endtask

    task automatic t_stamp;
        logic [31:0] v;
        wr(A_TS, 32'h100);
        rd(A_TS, v); chk("R2 load", v, 32'h100);
        step(5);
        rd(A_TS, v); chk("R2 count", v, 32'h105);
        wr(A_TS, 0);
        rd(A_TS, v); chk("R2 restart", v, 0);
        wr(A_TS, 32'hFFFF_FFFE);
        rd(A_TS, v); chk("R2 near top", v, 32'hFFFF_FFFE);
        rd(A_ST, v); chk("R3 no flag yet", v, 0);
        step(1);
        rd(A_TS, v); chk("R2 all ones", v, 32'hFFFF_FFFF);
        step(1);
        rd(A_TS, v); chk("R2 wrap", v, 0);
        rd(A_ST, v); chk("R3 wrap flag", v, 32'h4);
        wr(A_ST, 32'h4);
        rd(A_ST, v); chk("R10 clear bit2", v, 0);
    endtask

    task automatic t_periodic;
        logic [31:0] v;
        wr(A_K0, 32'h9);
        rd(A_C0, v); chk("R5 load", v, 8);
        step(3);
        rd(A_C0, v); chk("R5 decrement", v, 5);
        step(5);
        rd(A_C0, v); chk("R6 at zero", v, 0);
        rd(A_ST, v); chk("R6 not yet", v, 0);
        step(1);
        rd(A_ST, v); chk("R6 expired", v, 1);
        chk("R11 irq0 high", {30'd0, tmr_irq}, 1);
        rd(A_C0, v); chk("R6 reloaded", v, 8);
        step(9);
        rd(A_C0, v); chk("R6 period", v, 8);
        wr(A_K0, 0);
        wr(A_ST, 0);
        rd(A_ST, v); chk("R10 write0 no effect", v, 1);
        chk("R11 irq held", {30'd0, tmr_irq}, 1);
        wr(A_ST, 1);
        rd(A_ST, v); chk("R10 clear bit0", v, 0);
        chk("R11 irq dropped", {30'd0, tmr_irq}, 0);
    endtask

    task automatic t_oneshot;
        logic [31:0] v;
        wr(A_K0, 32'hF);
        rd(A_K0, v); chk("R4 readback", v, 32'hF);
        rd(A_C0, v); chk("R4 low bits zero", v, 12);
        step(12);
        rd(A_C0, v); chk("R7 zero", v, 0);
        rd(A_ST, v); chk("R7 not yet", v, 0);
        step(1);
        rd(A_ST, v); chk("R7 expired", v, 1);
        step(5);
        rd(A_C0, v); chk("R7 stays zero", v, 0);
        wr(A_ST, 1);
        step(20);
        rd(A_ST, v); chk("R7 no second flag", v, 0);
        rd(A_K0, v); chk("R4 ctrl kept", v, 32'hF);
        wr(A_K0, 0);
    endtask

    task automatic t_retune;
        logic [31:0] v;
        wr(A_K0, 32'h15);
        step(4);
        rd(A_C0, v); chk("R5 count 16", v, 16);
        wr(A_K0, 32'h9);
        rd(A_C0, v); chk("R8 count kept", v, 15);
        step(15);
        rd(A_C0, v); chk("R8 zero", v, 0);
        step(1);
        rd(A_C0, v); chk("R8 new reload", v, 8);
        rd(A_ST, v); chk("R8 flag", v, 1);
        wr(A_K0, 0);
        wr(A_ST, 1);
    endtask

    task automatic t_disable;
        logic [31:0] v;
        wr(A_K0, 32'h41);
        step(10);
        rd(A_C0, v); chk("R5 count 54", v, 54);
        wr(A_K0, 0);
        rd(A_C0, v); chk("R9 frozen", v, 54);
        step(70);
        rd(A_C0, v); chk("R9 still frozen", v, 54);
        rd(A_ST, v); chk("R9 no flag", v, 0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr(A_C0, 32'h1234);
        rd(A_C0, v); chk("R12 count write", v, 32'h1234);
        step(3);
        rd(A_C0, v); chk("R12 halted hold", v, 32'h1234);
        rd(8'h14, v); chk("R12 unmapped 14", v, 0);
        rd(8'h1C, v); chk("R12 unmapped 1C", v, 0);
        step(1);
        rd(8'h24, v); chk("R12 unmapped 24", v, 0);
    endtask

    task automatic t_timer1;
        logic [31:0] v;
        wr(A_K1, 32'h5);
        rd(A_C1, v); chk("R5 t1 load", v, 4);
        step(4);
        rd(A_ST, v); chk("R6 t1 not yet", v, 0);
        step(1);
        rd(A_ST, v); chk("R6 t1 flag", v, 2);
        chk("R11 irq1", {30'd0, tmr_irq}, 2);
        wr(A_K1, 0);
        wr(A_ST, 2);
        rd(A_ST, v); chk("R10 clear bit1", v, 0);
        chk("R11 irq1 low", {30'd0, tmr_irq}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stamp();
        t_periodic();
        t_oneshot();
        t_retune();
        t_disable();
        t_regs();
        t_timer1();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog got=hang exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule